// File: doc/BRIEF.md
# Dual-Personality Register Front End

This block sits in front of a storage-media controller that offers two programming models. After reset it runs in the legacy model: every bus access is forwarded unchanged to an external soft-switch block, whose read data is returned to the bus. In the second, richer model, the block itself decodes the low three address bits. It then serves a sixteen-entry parameter file with a self-advancing index, a phase register, a setup register, and a mode register. The mode register is changed through two separate ports, one that clears bits and one that sets them.

Bit 6 of the mode register chooses the model. Software can only enter the richer model from the legacy one with a fixed unlock sequence: four consecutive legacy writes to one address, whose data bit 6 must follow a set pattern. Any other legacy access on the way breaks the sequence. Clearing mode bit 6 returns control to the legacy model. While the richer model is active, mode bit 5 drives the head-select output.

Accesses are single-cycle register strobes rather than a data stream, so the bus side has no valid/ready handshake and no back-pressure. An access is taken on each rising clock edge at which `bus_en` is high. Read data is combinational from the state before that edge, and every side effect of the access appears after that edge.

Top module: `dualreg_front`

## Requirements
- R1: After reset the mode, setup and phase registers read 0, every parameter entry is 0, the parameter index is 0, and `head_sel_o` is 0. Because mode bit 6 is then 0, the block starts in the legacy model.
- R2: While mode bit 6 is 0, every access raises `leg_en` and returns `leg_rdata` on `bus_rdata`. While mode bit 6 is 1, `leg_en` stays low.
- R3: In the richer model, a read at address low bits 3 returns the parameter entry at the index. A write there stores the data at the index. Either access then advances the index modulo 16, so the 17th read after the index is cleared returns entry 0 again.
- R4: In the richer model, address low bits 4 read and write the phase register, and address low bits 5 read and write the setup register.
- R5: A write at address low bits 6 clears each mode bit whose data bit is 1 and returns the parameter index to 0.
- R6: A write at address low bits 7 sets each mode bit whose data bit is 1. A read at address low bits 6 returns the mode register.
- R7: In the richer model, reads at address low bits 0, 1, 2 and 7 return 0xFF. Writes at address low bits 0, 1 and 2 change no register. Address bit 3 is ignored.
- R8: Four consecutive legacy accesses that are all writes to address 0xF, with data bit 6 equal to 1, 0, 1, 1 in that order, set mode bit 6. The access that follows is decoded by the richer model.
- R9: A legacy access that is not the next step of the pattern (a read, another address, or the wrong bit 6) returns the unlock progress to the start. A complete fresh four-write pattern is then needed.
- R10: `head_sel_o` equals mode bit 5 while mode bit 6 is 1, and is 0 otherwise.
- R11: Clearing mode bit 6 through address low bits 6 sends the next access to the legacy port, and unlock progress starts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access strobe, taken at the rising edge |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Access address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current access |
| leg_en | output | 1 | Access forwarded to the legacy soft-switch logic |
| leg_wr | output | 1 | Forwarded write flag |
| leg_addr | output | 4 | Forwarded address |
| leg_wdata | output | 8 | Forwarded write data |
| leg_rdata | input | 8 | Read data from the legacy soft-switch logic |
| phase_o | output | 8 | Phase register |
| setup_o | output | 8 | Setup register |
| mode_o | output | 8 | Mode register |
| head_sel_o | output | 1 | Head-select output |

## Verification
The richer-model decoder is exercised with a table of mixed reads and writes that covers every offset. An alias with address bit 3 set separates true three-bit decoding from full-address decoding. An index wrap of seventeen reads separates a modulo-16 index from a saturating one. The unlock detector is given the correct pattern, a pattern with a repeated 1 at the second step, a pattern broken by a read at the final step, and one broken by a write to another address. A pass-through leg_en check and a legacy read compared against a fixed `leg_rdata` value tell correct routing apart from decoding the access locally.

// File: rtl/dualreg_pkg.sv
package dualreg_pkg;
  localparam int DEC_W = 3;

  typedef enum logic [DEC_W-1:0] {
    OFS_PARAM = 3'd3,
    OFS_PHASE = 3'd4,
    OFS_SETUP = 3'd5,
    OFS_MCLR  = 3'd6,
    OFS_MSET  = 3'd7
  } ofs_e;

  localparam int MODE_PERS_BIT = 6;
  localparam int MODE_HEAD_BIT = 5;
  localparam int UNLOCK_DBIT   = 6;
endpackage

// File: rtl/dualreg_param_file.sv
module dualreg_param_file #(
  parameter int DW     = 8,
  parameter int PDEPTH = 16,
  localparam int IDX_W = $clog2(PDEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_step,
  input  logic          wr_step,
  input  logic          idx_clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    ent_q [PDEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_clr) idx_q <= '0;
    else if (rd_step || wr_step) idx_q <= idx_q + 1'b1;
  end

  for (genvar g = 0; g < PDEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= '0;
      else if (wr_step && (idx_q == IDX_W'(g))) ent_q[g] <= wdata;
    end
  end

  assign rdata = ent_q[idx_q];
endmodule

// File: rtl/dualreg_unlock_det.sv
module dualreg_unlock_det #(
  parameter int          AW      = 4,
  parameter int          DW      = 8,
  parameter logic [AW-1:0] KEY_ADDR = '1,
  parameter int          KEY_BIT = 6,
  parameter int          KEY_LEN = 4,
  parameter logic [KEY_LEN-1:0] KEY_PAT = 4'b1011,
  localparam int         CW      = $clog2(KEY_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_legacy,
  input  logic          leg_acc,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          hit
);
  logic [CW-1:0] cnt_q;
  logic          want;
  logic          adv;

  always_comb begin
    want = KEY_PAT[KEY_LEN-1-int'(cnt_q)];
    adv  = leg_acc && wr && (addr == KEY_ADDR) && (wdata[KEY_BIT] == want);
    hit  = adv && (cnt_q == CW'(KEY_LEN-1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!in_legacy) cnt_q <= '0;
    else if (leg_acc) begin
      if (adv && !hit) cnt_q <= cnt_q + 1'b1;
      else cnt_q <= '0;
    end
  end
endmodule

// File: rtl/dualreg_mode_reg.sv
module dualreg_mode_reg #(
  parameter int DW       = 8,
  parameter int PERS_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_en,
  input  logic          set_en,
  input  logic          unlock,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode
);
  logic [DW-1:0] clr_m, set_m;

  always_comb begin
    clr_m = clr_en ? wdata : '0;
    set_m = set_en ? wdata : '0;
    if (unlock) set_m[PERS_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= '0;
    else if (clr_en || set_en || unlock) mode <= (mode & ~clr_m) | set_m;
  end
endmodule

// File: rtl/dualreg_front.sv
module dualreg_front
  import dualreg_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 4,
  parameter int PDEPTH = 16,
  parameter logic [AW-1:0] UNLOCK_ADDR = 4'hF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          leg_en,
  output logic          leg_wr,
  output logic [AW-1:0] leg_addr,
  output logic [DW-1:0] leg_wdata,
  input  logic [DW-1:0] leg_rdata,
  output logic [DW-1:0] phase_o,
  output logic [DW-1:0] setup_o,
  output logic [DW-1:0] mode_o,
  output logic          head_sel_o
);
  logic          pers_new;
  logic          new_acc, new_rd, new_wr;
  ofs_e          ofs;
  logic [DW-1:0] prm_rdata;
  logic          unlock_hit;
  logic [DW-1:0] phase_q, setup_q;

  assign pers_new  = mode_o[MODE_PERS_BIT];
  assign new_acc   = bus_en && pers_new;
  assign new_rd    = new_acc && !bus_wr;
  assign new_wr    = new_acc && bus_wr;
  assign ofs       = ofs_e'(bus_addr[DEC_W-1:0]);

  assign leg_en    = bus_en && !pers_new;
  assign leg_wr    = bus_wr;
  assign leg_addr  = bus_addr;
  assign leg_wdata = bus_wdata;

  dualreg_param_file #(.DW(DW), .PDEPTH(PDEPTH)) u_prm (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_step (new_rd && ofs == OFS_PARAM),
    .wr_step (new_wr && ofs == OFS_PARAM),
    .idx_clr (new_wr && ofs == OFS_MCLR),
    .wdata   (bus_wdata),
    .rdata   (prm_rdata)
  );

  dualreg_unlock_det #(
    .AW(AW), .DW(DW), .KEY_ADDR(UNLOCK_ADDR), .KEY_BIT(UNLOCK_DBIT)
  ) u_unl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_legacy (!pers_new),
    .leg_acc   (leg_en),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .hit       (unlock_hit)
  );

  dualreg_mode_reg #(.DW(DW), .PERS_BIT(MODE_PERS_BIT)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_en (new_wr && ofs == OFS_MCLR),
    .set_en (new_wr && ofs == OFS_MSET),
    .unlock (unlock_hit),
    .wdata  (bus_wdata),
    .mode   (mode_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      setup_q <= '0;
    end else if (new_wr) begin
      if (ofs == OFS_PHASE) phase_q <= bus_wdata;
      if (ofs == OFS_SETUP) setup_q <= bus_wdata;
    end
  end

  always_comb begin
    if (!pers_new) bus_rdata = leg_rdata;
    else begin
      case (ofs)
        OFS_PARAM: bus_rdata = prm_rdata;
        OFS_PHASE: bus_rdata = phase_q;
        OFS_SETUP: bus_rdata = setup_q;
        OFS_MCLR:  bus_rdata = mode_o;
        default:   bus_rdata = '1;
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign setup_o    = setup_q;
  assign head_sel_o = pers_new && mode_o[MODE_HEAD_BIT];
endmodule

// File: rtl/dualreg_front_chk.sv
module dualreg_front_chk #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [AW-1:0] UNLOCK_ADDR = 4'hF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          leg_en,
  input logic [DW-1:0] phase_o,
  input logic [DW-1:0] mode_o,
  input logic          head_sel_o
);
  assert_legacy_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !mode_o[6]) |-> leg_en);

  assert_new_no_legacy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[6] |-> !leg_en);

  assert_mode_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && mode_o[6] && bus_addr[2:0] == 3'd7)
      |=> ((mode_o & $past(bus_wdata)) == $past(bus_wdata)));

  assert_mode_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && mode_o[6] && bus_addr[2:0] == 3'd6)
      |=> ((mode_o & $past(bus_wdata)) == '0));

  assert_unlock_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_o[6]) |-> $past(bus_en && bus_wr && bus_addr == UNLOCK_ADDR && bus_wdata[6]));

  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_wr && mode_o[6] && bus_addr[2:0] == 3'd4) |=> $stable(phase_o));

  assert_head_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_o[6] |-> !head_sel_o);
endmodule

bind dualreg_front dualreg_front_chk #(.DW(DW), .AW(AW), .UNLOCK_ADDR(UNLOCK_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en     (bus_en),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .leg_en     (leg_en),
  .phase_o    (phase_o),
  .mode_o     (mode_o),
  .head_sel_o (head_sel_o)
);

// File: tb/dualreg_front_tb.sv
module dualreg_front_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LEG_VAL = 8'h5A;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_en = 0, bus_wr = 0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       leg_en, leg_wr;
  logic [3:0] leg_addr;
  logic [7:0] leg_wdata;
  logic [7:0] leg_rdata = LEG_VAL;
  logic [7:0] phase_o, setup_o, mode_o;
  logic       head_sel_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dualreg_front u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .leg_en(leg_en), .leg_wr(leg_wr), .leg_addr(leg_addr), .leg_wdata(leg_wdata),
    .leg_rdata(leg_rdata), .phase_o(phase_o), .setup_o(setup_o), .mode_o(mode_o),
    .head_sel_o(head_sel_o)
  );

  // row: {req, wr, addr, wdata, expected read}
  localparam int NV = 24;
  localparam logic [24:0] VEC [NV] = '{
    {4'd3, 1'b1, 4'h3, 8'h11, 8'h00},  // R3 fill entries
    {4'd3, 1'b1, 4'h3, 8'h22, 8'h00},
    {4'd3, 1'b1, 4'h3, 8'h33, 8'h00},
    {4'd5, 1'b1, 4'h6, 8'h00, 8'h00},  // R5 index back to 0
    {4'd6, 1'b0, 4'h6, 8'h00, 8'h40},  // R6 mode read
    {4'd3, 1'b0, 4'h3, 8'h00, 8'h11},
    {4'd3, 1'b0, 4'h3, 8'h00, 8'h22},
    {4'd3, 1'b0, 4'h3, 8'h00, 8'h33},
    {4'd3, 1'b0, 4'h3, 8'h00, 8'h00},
    {4'd4, 1'b1, 4'h4, 8'hA5, 8'h00},  // R4 phases
    {4'd4, 1'b0, 4'h4, 8'h00, 8'hA5},
    {4'd4, 1'b1, 4'h5, 8'h3C, 8'h00},  // R4 setup
    {4'd4, 1'b0, 4'h5, 8'h00, 8'h3C},
    {4'd7, 1'b0, 4'hC, 8'h00, 8'hA5},  // R7 bit 3 ignored
    {4'd7, 1'b0, 4'h0, 8'h00, 8'hFF},
    {4'd7, 1'b0, 4'h1, 8'h00, 8'hFF},
    {4'd7, 1'b0, 4'h2, 8'h00, 8'hFF},
    {4'd7, 1'b0, 4'h7, 8'h00, 8'hFF},
    {4'd6, 1'b1, 4'h7, 8'h21, 8'h00},  // R6 set bits
    {4'd6, 1'b0, 4'h6, 8'h00, 8'h61},
    {4'd5, 1'b1, 4'h6, 8'h01, 8'h00},  // R5 clear bit
    {4'd5, 1'b0, 4'h6, 8'h00, 8'h60},
    {4'd7, 1'b1, 4'h0, 8'h12, 8'h00},  // R7 write ignored
    {4'd7, 1'b0, 4'h4, 8'h00, 8'hA5}
  };

  task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [3:0] a, input logic [7:0] d,
                     output logic [7:0] rd, output logic le);
    bus_en = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    rd = bus_rdata; le = leg_en;
    @(posedge clk); #1;
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic unlock_seq(input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input logic [7:0] d3);
    logic [7:0] rd; logic le;
    acc(1'b1, 4'hF, d0, rd, le);
    acc(1'b1, 4'hF, d1, rd, le);
    acc(1'b1, 4'hF, d2, rd, le);
    acc(1'b1, 4'hF, d3, rd, le);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic le;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    chk(1, "mode after reset", mode_o, 8'h00);
    chk(1, "setup after reset", setup_o, 8'h00);
    chk(1, "phase after reset", phase_o, 8'h00);
    chk(1, "head_sel after reset", {7'd0, head_sel_o}, 8'h00);

    // R2 legacy routing
    acc(1'b0, 4'h3, 8'h00, rd, le);
    chk(2, "legacy read data", rd, LEG_VAL);
    chk(2, "legacy strobe", {7'd0, le}, 8'h01);

    // R8 unlock
    acc(1'b1, 4'hF, 8'h40, rd, le);
    acc(1'b1, 4'hF, 8'h00, rd, le);
    acc(1'b1, 4'hF, 8'h40, rd, le);
    chk(8, "mode before last unlock write", mode_o, 8'h00);
    acc(1'b1, 4'hF, 8'h40, rd, le);
    chk(8, "mode after unlock", mode_o, 8'h40);

    // table walk in the richer model
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      acc(v[20], v[19:16], v[15:8], rd, le);
      chk(int'(v[24:21]), "leg_en in richer model", {7'd0, le}, 8'h00);
      if (!v[20]) chk(int'(v[24:21]), $sformatf("table row %0d", i), rd, v[7:0]);
    end

    // R10 head select follows mode bit 5
    chk(10, "head_sel with mode 60", {7'd0, head_sel_o}, 8'h01);
    acc(1'b1, 4'h6, 8'h20, rd, le);
    chk(10, "head_sel after clearing bit5", {7'd0, head_sel_o}, 8'h00);

    // R3 index wrap
    acc(1'b1, 4'h6, 8'h00, rd, le);
    for (int k = 0; k < 16; k++) acc(1'b0, 4'h3, 8'h00, rd, le);
    acc(1'b0, 4'h3, 8'h00, rd, le);
    chk(3, "param read after wrap", rd, 8'h11);

    // R11 leave richer model
    acc(1'b1, 4'h7, 8'h20, rd, le);
    acc(1'b1, 4'h6, 8'h40, rd, le);
    acc(1'b0, 4'h4, 8'h00, rd, le);
    chk(11, "routing after clearing bit6", rd, LEG_VAL);
    chk(11, "legacy strobe after clearing bit6", {7'd0, le}, 8'h01);
    chk(10, "head_sel in legacy with bit5 set", {7'd0, head_sel_o}, 8'h00);

    // R9 broken sequences
    acc(1'b1, 4'hF, 8'h40, rd, le);
    acc(1'b1, 4'hF, 8'h40, rd, le);   // wrong bit at step 2 -> restart
    unlock_seq(8'h00, 8'h40, 8'h00, 8'h40); // 0 restarts, then 1,0,1 only 3 steps
    chk(9, "mode after repeated-1 break", mode_o, 8'h20);
    acc(1'b0, 4'hF, 8'h00, rd, le);   // read breaks after three steps
    acc(1'b1, 4'hF, 8'h40, rd, le);
    chk(9, "mode after read break", mode_o, 8'h20);
    acc(1'b0, 4'h0, 8'h00, rd, le);   // clear progress
    acc(1'b1, 4'hF, 8'h40, rd, le);
    acc(1'b1, 4'hF, 8'h00, rd, le);
    acc(1'b1, 4'hE, 8'h40, rd, le);   // other address breaks
    acc(1'b1, 4'hF, 8'h40, rd, le);
    acc(1'b1, 4'hF, 8'h40, rd, le);
    chk(9, "mode after address break", mode_o, 8'h20);

    // R8 / R11 fresh sequence from start works again
    acc(1'b0, 4'h0, 8'h00, rd, le);
    unlock_seq(8'h40, 8'h00, 8'h40, 8'h40);
    chk(8, "mode after fresh unlock", mode_o, 8'h60);
    chk(10, "head_sel after relock", {7'd0, head_sel_o}, 8'h01);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule